// File: doc/BRIEF.md
# PC/PCI DMA cycle sequencer

This block carries out one DMA service request as a pair of separate bus cycles: a load and then a store. Data moves through an internal 16-bit holding register instead of passing directly between the two ends. A request names the direction (memory to I/O, I/O to memory, verify or cascade), a terminal-count flag, the port size (byte or word) and the memory address. The block then drives abstract memory and I/O cycle commands on a request/done handshake. Each command carries an address, byte enables and write data, and read data returns with the done strobe.

The I/O side of every transfer goes to a fixed I/O address. That address tells the device two things: whether the cycle is a normal transfer or a verify, and whether terminal count has been reached. I/O cycles are gated by the grant to the requesting device. If the grant is missing at the moment an I/O phase would begin, the sequencer stops the transfer and reports an abort. Cascade channels serve an external bus master, so they are only acknowledged and produce no cycles.

Top module: `dma_xfer_seq`

## Requirements
- R1: With `req_dir` = 0 (memory to I/O), the block issues exactly two cycles. The first is a memory read at `req_addr`. The second is an I/O write whose data carries the port-sized value taken from the addressed memory byte lanes. For a byte port the data sits on bits 7:0 with the rest zero; for a word port it sits on bits 15:0.
- R2: With `req_dir` = 1 (I/O to memory), the block issues exactly two cycles. The first is an I/O read. The second is a memory write at `req_addr` carrying the I/O read data, which is bits 7:0 for a byte port or bits 15:0 for a word port, placed on the lanes selected by the low address bits. All other lanes are zero.
- R3: The I/O cycle address is zero-extended from an 8-bit code. The code is 00h for a normal transfer, 04h for a normal transfer at terminal count (`req_tc` = 1), C0h for verify and C4h for verify at terminal count.
- R4: With `req_dir` = 2 (verify), the block issues only one I/O read and no memory cycle. It never issues a write.
- R5: An I/O cycle starts only if `gnt` was high at the clock edge where that cycle begins.
- R6: If `gnt` is low when an I/O phase is due, the block issues no further cycle. It then pulses `xfer_done` with `xfer_abort` = 1. In the memory-to-I/O case the memory read has already completed at that point and the I/O write is dropped.
- R7: Memory byte enables are derived from `req_addr[1:0]`. A byte port enables the single lane at that offset, and a word port enables that lane and the next one. I/O cycles enable lane 0 for a byte port and lanes 0 and 1 for a word port.
- R8: A word request at an odd address, for direction 0 or 1, issues no cycle. It pulses `xfer_done` with `xfer_err` = 1 one cycle after acceptance. Verify requests are exempt from this check.
- R9: With `req_dir` = 3 (cascade), the block issues no cycle. It pulses `xfer_done` with `xfer_abort` = 0 and `xfer_err` = 0.
- R10: A request presented while `busy` is high is ignored. It adds no cycle and no done pulse.
- R11: During and after reset the block is idle: `busy`, `cyc_req` and `xfer_done` are low. `xfer_abort` and `xfer_err` are high only together with `xfer_done`.
- R12: Once raised, `cyc_req` stays high with its address, type and byte enables unchanged until `cyc_done` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Service request, accepted when idle |
| req_dir | input | 2 | 0 memory to I/O, 1 I/O to memory, 2 verify, 3 cascade |
| req_tc | input | 1 | Terminal count reached with this transfer |
| req_word | input | 1 | Port size: 1 word, 0 byte |
| req_addr | input | ADDR_W | Memory address of the transfer |
| gnt | input | 1 | Grant to the requesting device |
| busy | output | 1 | Transfer in progress |
| cyc_req | output | 1 | Bus cycle command valid |
| cyc_io | output | 1 | 1 I/O cycle, 0 memory cycle |
| cyc_wr | output | 1 | 1 write, 0 read |
| cyc_addr | output | ADDR_W | Cycle address |
| cyc_be | output | DATA_W/8 | Byte enables |
| cyc_wdata | output | DATA_W | Write data, zero on reads |
| cyc_done | input | 1 | Cycle completed; read data valid |
| cyc_rdata | input | DATA_W | Read data |
| xfer_done | output | 1 | One-cycle transfer-complete strobe |
| xfer_abort | output | 1 | With xfer_done: stopped for lack of grant |
| xfer_err | output | 1 | With xfer_done: misaligned word request |

## Verification
A vector table covers every combination of direction, terminal count and port size, with memory offsets on each byte lane. Those entries tell apart lane placement on stores from lane extraction on loads, and the four I/O address codes from one another. Read data includes unrelated upper bytes, so a missing mask on byte ports shows up. Further entries remove the grant at each possible I/O phase to separate an abort after a load from an abort before any cycle. Misaligned words are tried for both directions that move data and for verify, which must not be rejected. A directed run with wait states and requests injected while busy shows that in-flight commands hold steady and that extra requests are dropped.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    DIR_MEM2IO  = 2'd0,
    DIR_IO2MEM  = 2'd1,
    DIR_VERIFY  = 2'd2,
    DIR_CASCADE = 2'd3
  } dir_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_MEM_RD = 3'd1,
    PH_IO_RD  = 3'd2,
    PH_IO_WR  = 3'd3,
    PH_MEM_WR = 3'd4
  } phase_e;

  typedef struct packed {
    dir_e dir;
    logic tc;
    logic word;
  } xfer_attr_t;

  // I/O address codes: type and terminal count are visible to the device
  localparam logic [7:0] IOA_NORM    = 8'h00;
  localparam logic [7:0] IOA_NORM_TC = 8'h04;
  localparam logic [7:0] IOA_VFY     = 8'hC0;
  localparam logic [7:0] IOA_VFY_TC  = 8'hC4;

  localparam int unsigned PORT_W = 16;

endpackage

// File: rtl/dma_rst_sync.sv
module dma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dma_req_latch.sv
module dma_req_latch
  import dma_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              ld_en,
  input  xfer_attr_t        attr_d,
  input  logic [ADDR_W-1:0] addr_d,
  output xfer_attr_t        attr_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      attr_q <= '{dir: DIR_MEM2IO, tc: 1'b0, word: 1'b0};
      addr_q <= '0;
    end else if (ld_en) begin
      attr_q <= attr_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/dma_phase_fsm.sv
module dma_phase_fsm
  import dma_xfer_pkg::*;
(
  input  logic   clk,
  input  logic   srst_n,
  input  logic   req_valid,
  input  dir_e   req_dir,
  input  logic   req_word,
  input  logic   req_addr_lsb,
  input  dir_e   lat_dir,
  input  logic   gnt,
  input  logic   cyc_done,
  output phase_e phase,
  output logic   accept,
  output logic   cap_en,
  output logic   done_q,
  output logic   abort_q,
  output logic   err_q
);
  phase_e ph_q, ph_nx;
  logic   done_nx, abort_nx, err_nx;

  assign accept = (ph_q == PH_IDLE) && req_valid;

  always_comb begin
    ph_nx    = ph_q;
    done_nx  = 1'b0;
    abort_nx = 1'b0;
    err_nx   = 1'b0;
    cap_en   = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (req_dir == DIR_CASCADE) begin
            done_nx = 1'b1;
          end else if (req_word && req_addr_lsb && (req_dir != DIR_VERIFY)) begin
            done_nx = 1'b1;
            err_nx  = 1'b1;
          end else if (req_dir == DIR_MEM2IO) begin
            ph_nx = PH_MEM_RD;
          end else if (gnt) begin
            ph_nx = PH_IO_RD;
          end else begin
            done_nx  = 1'b1;
            abort_nx = 1'b1;
          end
        end
      end
      PH_MEM_RD: begin
        if (cyc_done) begin
          cap_en = 1'b1;
          if (gnt) begin
            ph_nx = PH_IO_WR;
          end else begin
            ph_nx    = PH_IDLE;
            done_nx  = 1'b1;
            abort_nx = 1'b1;
          end
        end
      end
      PH_IO_RD: begin
        if (cyc_done) begin
          if (lat_dir == DIR_VERIFY) begin
            ph_nx   = PH_IDLE;
            done_nx = 1'b1;
          end else begin
            cap_en = 1'b1;
            ph_nx  = PH_MEM_WR;
          end
        end
      end
      PH_IO_WR, PH_MEM_WR: begin
        if (cyc_done) begin
          ph_nx   = PH_IDLE;
          done_nx = 1'b1;
        end
      end
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ph_q    <= PH_IDLE;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ph_q    <= ph_nx;
      done_q  <= done_nx;
      abort_q <= abort_nx;
      err_q   <= err_nx;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/dma_lane_map.sv
module dma_lane_map
  import dma_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  phase_e              phase,
  input  xfer_attr_t          attr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PORT_W-1:0]   hold_q,
  input  logic [DATA_W-1:0]   cyc_rdata,
  output logic                cyc_req,
  output logic                cyc_io,
  output logic                cyc_wr,
  output logic [ADDR_W-1:0]   cyc_addr,
  output logic [DATA_W/8-1:0] cyc_be,
  output logic [DATA_W-1:0]   cyc_wdata,
  output logic [PORT_W-1:0]   cap_val
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned LSW   = $clog2(LANES);

  logic [LSW-1:0]    lsel;
  logic [LSW:0]      lsel_w;
  logic [LSW:0]      lsel_p1;
  logic [LANES-1:0]  mem_be, io_be;
  logic [DATA_W-1:0] mem_wd, io_wd;
  logic [7:0]        mem_lo, mem_hi;
  logic [7:0]        io_code;

  assign lsel    = addr[LSW-1:0];
  assign lsel_w  = {1'b0, lsel};
  assign lsel_p1 = lsel_w + (LSW+1)'(1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LSW:0] IDX = (LSW+1)'(g);
    logic lo_hit, hi_hit;
    assign lo_hit = (lsel_w == IDX);
    assign hi_hit = attr.word && (lsel_p1 == IDX);
    assign mem_be[g]       = lo_hit || hi_hit;
    assign mem_wd[8*g +: 8] = lo_hit ? hold_q[7:0] : (hi_hit ? hold_q[15:8] : 8'h00);
  end

  // Pick the port-sized value out of the addressed memory lanes
  always_comb begin
    mem_lo = 8'h00;
    mem_hi = 8'h00;
    for (int i = 0; i < LANES; i++) begin
      if (lsel_w == (LSW+1)'(i))  mem_lo = cyc_rdata[8*i +: 8];
      if (lsel_p1 == (LSW+1)'(i)) mem_hi = cyc_rdata[8*i +: 8];
    end
  end

  assign io_be = attr.word ? LANES'(2'b11) : LANES'(1'b1);
  assign io_wd = DATA_W'({(attr.word ? hold_q[15:8] : 8'h00), hold_q[7:0]});

  always_comb begin
    unique case ({attr.dir == DIR_VERIFY, attr.tc})
      2'b00:   io_code = IOA_NORM;
      2'b01:   io_code = IOA_NORM_TC;
      2'b10:   io_code = IOA_VFY;
      default: io_code = IOA_VFY_TC;
    endcase
  end

  always_comb begin
    cyc_req   = 1'b1;
    cyc_io    = 1'b0;
    cyc_wr    = 1'b0;
    cyc_addr  = addr;
    cyc_be    = mem_be;
    cyc_wdata = '0;
    unique case (phase)
      PH_MEM_RD: ;
      PH_MEM_WR: begin
        cyc_wr    = 1'b1;
        cyc_wdata = mem_wd;
      end
      PH_IO_RD: begin
        cyc_io   = 1'b1;
        cyc_addr = ADDR_W'(io_code);
        cyc_be   = io_be;
      end
      PH_IO_WR: begin
        cyc_io    = 1'b1;
        cyc_wr    = 1'b1;
        cyc_addr  = ADDR_W'(io_code);
        cyc_be    = io_be;
        cyc_wdata = io_wd;
      end
      default: begin
        cyc_req  = 1'b0;
        cyc_addr = '0;
        cyc_be   = '0;
      end
    endcase
  end

  always_comb begin
    if (phase == PH_MEM_RD)
      cap_val = {(attr.word ? mem_hi : 8'h00), mem_lo};
    else
      cap_val = {(attr.word ? cyc_rdata[15:8] : 8'h00), cyc_rdata[7:0]};
  end
endmodule

// File: rtl/dma_hold_reg.sv
module dma_hold_reg
  import dma_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              srst_n,
  input  logic              cap_en,
  input  logic [PORT_W-1:0] cap_val,
  output logic [PORT_W-1:0] hold_q
);
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     hold_q <= '0;
    else if (cap_en) hold_q <= cap_val;
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_dir,
  input  logic                req_tc,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                gnt,
  output logic                busy,
  output logic                cyc_req,
  output logic                cyc_io,
  output logic                cyc_wr,
  output logic [ADDR_W-1:0]   cyc_addr,
  output logic [DATA_W/8-1:0] cyc_be,
  output logic [DATA_W-1:0]   cyc_wdata,
  input  logic                cyc_done,
  input  logic [DATA_W-1:0]   cyc_rdata,
  output logic                xfer_done,
  output logic                xfer_abort,
  output logic                xfer_err
);
  logic              srst_n;
  logic              accept, cap_en;
  phase_e            phase;
  xfer_attr_t        req_attr, lat_attr;
  dir_e              lat_dir;
  logic [ADDR_W-1:0] lat_addr;
  logic [PORT_W-1:0] hold_q, cap_val;

  assign req_attr = '{dir: dir_e'(req_dir), tc: req_tc, word: req_word};
  assign lat_dir  = lat_attr.dir;
  assign busy     = (phase != PH_IDLE);

  dma_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dma_req_latch #(.ADDR_W(ADDR_W)) u_latch (
    .clk    (clk),
    .srst_n (srst_n),
    .ld_en  (accept),
    .attr_d (req_attr),
    .addr_d (req_addr),
    .attr_q (lat_attr),
    .addr_q (lat_addr)
  );

  dma_phase_fsm u_fsm (
    .clk          (clk),
    .srst_n       (srst_n),
    .req_valid    (req_valid),
    .req_dir      (req_attr.dir),
    .req_word     (req_word),
    .req_addr_lsb (req_addr[0]),
    .lat_dir      (lat_dir),
    .gnt          (gnt),
    .cyc_done     (cyc_done),
    .phase        (phase),
    .accept       (accept),
    .cap_en       (cap_en),
    .done_q       (xfer_done),
    .abort_q      (xfer_abort),
    .err_q        (xfer_err)
  );

  dma_lane_map #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
    .phase     (phase),
    .attr      (lat_attr),
    .addr      (lat_addr),
    .hold_q    (hold_q),
    .cyc_rdata (cyc_rdata),
    .cyc_req   (cyc_req),
    .cyc_io    (cyc_io),
    .cyc_wr    (cyc_wr),
    .cyc_addr  (cyc_addr),
    .cyc_be    (cyc_be),
    .cyc_wdata (cyc_wdata),
    .cap_val   (cap_val)
  );

  dma_hold_reg u_hold (
    .clk     (clk),
    .srst_n  (srst_n),
    .cap_en  (cap_en),
    .cap_val (cap_val),
    .hold_q  (hold_q)
  );
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk
  import dma_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                gnt,
  input logic                busy,
  input logic                cyc_req,
  input logic                cyc_io,
  input logic                cyc_wr,
  input logic [ADDR_W-1:0]   cyc_addr,
  input logic [DATA_W/8-1:0] cyc_be,
  input logic                cyc_done,
  input logic                xfer_done,
  input logic                xfer_abort,
  input logic                xfer_err,
  input dir_e                lat_dir
);
  p_io_needs_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && cyc_io && !$past(cyc_req && cyc_io)) |-> $past(gnt));

  p_verify_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && lat_dir == DIR_VERIFY) |-> (cyc_io && !cyc_wr));

  p_io_addr_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && cyc_io) |-> (cyc_addr == ADDR_W'(8'h00) || cyc_addr == ADDR_W'(8'h04) ||
                             cyc_addr == ADDR_W'(8'hC0) || cyc_addr == ADDR_W'(8'hC4)));

  p_be_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_req |-> ($countones(cyc_be) == 1 || $countones(cyc_be) == 2));

  p_cmd_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_req && !cyc_done) |=> (cyc_req && $stable(cyc_addr) && $stable(cyc_io) &&
                                $stable(cyc_wr) && $stable(cyc_be)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cyc_req);

  p_flags_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |-> (!xfer_abort && !xfer_err));

  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !(xfer_abort && xfer_err));
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dma_xfer_seq_test.sv
module dma_xfer_seq_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam logic [1:0] MR = 2'b00, MW = 2'b01, IR = 2'b10, IW = 2'b11;

  typedef struct packed {
    logic [1:0]  dir;
    logic        tc;
    logic        word;
    logic        gnt;
    logic [31:0] addr;
    logic [31:0] rdata;
    logic [1:0]  n;
    logic [1:0]  k0;
    logic [31:0] a0;
    logic [3:0]  b0;
    logic [1:0]  k1;
    logic [31:0] a1;
    logic [3:0]  b1;
    logic [31:0] wd;
    logic        ab;
    logic        er;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0,1'b0,1'b0,1'b1,32'h1000_0002,32'hA1B2C3D4,2'd2,MR,32'h1000_0002,4'b0100,IW,32'h0000_0000,4'b0001,32'h0000_00B2,1'b0,1'b0},
    '{2'd0,1'b1,1'b1,1'b1,32'h2000_0002,32'h11223344,2'd2,MR,32'h2000_0002,4'b1100,IW,32'h0000_0004,4'b0011,32'h0000_1122,1'b0,1'b0},
    '{2'd1,1'b0,1'b0,1'b1,32'h3000_0001,32'hDEADBE5A,2'd2,IR,32'h0000_0000,4'b0001,MW,32'h3000_0001,4'b0010,32'h0000_5A00,1'b0,1'b0},
    '{2'd1,1'b1,1'b1,1'b1,32'h3000_0000,32'hCAFE9876,2'd2,IR,32'h0000_0004,4'b0011,MW,32'h3000_0000,4'b0011,32'h0000_9876,1'b0,1'b0},
    '{2'd1,1'b0,1'b1,1'b1,32'h4000_0002,32'h1234ABCD,2'd2,IR,32'h0000_0000,4'b0011,MW,32'h4000_0002,4'b1100,32'hABCD_0000,1'b0,1'b0},
    '{2'd2,1'b0,1'b0,1'b1,32'h5000_0000,32'h0000_0011,2'd1,IR,32'h0000_00C0,4'b0001,MR,32'h0,4'b0,32'h0,1'b0,1'b0},
    '{2'd2,1'b1,1'b1,1'b1,32'h5000_0005,32'h0000_FFFF,2'd1,IR,32'h0000_00C4,4'b0011,MR,32'h0,4'b0,32'h0,1'b0,1'b0},
    '{2'd0,1'b0,1'b0,1'b0,32'h6000_0003,32'h99887766,2'd1,MR,32'h6000_0003,4'b1000,MR,32'h0,4'b0,32'h0,1'b1,1'b0},
    '{2'd1,1'b1,1'b0,1'b0,32'h7000_0000,32'h0000_0000,2'd0,MR,32'h0,4'b0,MR,32'h0,4'b0,32'h0,1'b1,1'b0},
    '{2'd2,1'b0,1'b0,1'b0,32'h7000_0000,32'h0000_0000,2'd0,MR,32'h0,4'b0,MR,32'h0,4'b0,32'h0,1'b1,1'b0},
    '{2'd0,1'b0,1'b1,1'b1,32'h8000_0001,32'h0000_0000,2'd0,MR,32'h0,4'b0,MR,32'h0,4'b0,32'h0,1'b0,1'b1},
    '{2'd1,1'b0,1'b1,1'b1,32'h8000_0003,32'h0000_0000,2'd0,MR,32'h0,4'b0,MR,32'h0,4'b0,32'h0,1'b0,1'b1},
    '{2'd3,1'b0,1'b0,1'b1,32'h9000_0000,32'h0000_0000,2'd0,MR,32'h0,4'b0,MR,32'h0,4'b0,32'h0,1'b0,1'b0},
    '{2'd1,1'b0,1'b0,1'b1,32'hA000_0003,32'hFFFFFF77,2'd2,IR,32'h0000_0000,4'b0001,MW,32'hA000_0003,4'b1000,32'h7700_0000,1'b0,1'b0}
  };

  logic          clk, rst_n;
  logic          req_valid, req_tc, req_word, gnt;
  logic [1:0]    req_dir;
  logic [AW-1:0] req_addr;
  logic          busy, cyc_req, cyc_io, cyc_wr, cyc_done;
  logic [AW-1:0] cyc_addr;
  logic [3:0]    cyc_be;
  logic [DW-1:0] cyc_wdata, cyc_rdata;
  logic          xfer_done, xfer_abort, xfer_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // responder log
  logic [1:0]  lg_kind [64];
  logic [31:0] lg_addr [64];
  logic [3:0]  lg_be   [64];
  logic [31:0] lg_wd   [64];
  int          log_n = 0;
  int          done_cnt = 0;
  int          resp_wait = 0;
  logic [31:0] resp_data = '0;

  dma_xfer_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
    .req_tc(req_tc), .req_word(req_word), .req_addr(req_addr), .gnt(gnt),
    .busy(busy), .cyc_req(cyc_req), .cyc_io(cyc_io), .cyc_wr(cyc_wr),
    .cyc_addr(cyc_addr), .cyc_be(cyc_be), .cyc_wdata(cyc_wdata),
    .cyc_done(cyc_done), .cyc_rdata(cyc_rdata), .xfer_done(xfer_done),
    .xfer_abort(xfer_abort), .xfer_err(xfer_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // bus responder: answers each command once, after resp_wait idle cycles
  initial begin
    int wcnt;
    wcnt = 0;
    cyc_done = 1'b0;
    cyc_rdata = '0;
    forever begin
      @(negedge clk);
      if (xfer_done) done_cnt++;
      if (cyc_done) begin
        cyc_done = 1'b0;
        wcnt = 0;
      end else if (cyc_req) begin
        if (wcnt < resp_wait) wcnt++;
        else begin
          lg_kind[log_n % 64] = {cyc_io, cyc_wr};
          lg_addr[log_n % 64] = cyc_addr;
          lg_be[log_n % 64]   = cyc_be;
          lg_wd[log_n % 64]   = cyc_wdata;
          log_n++;
          cyc_rdata = resp_data;
          cyc_done  = 1'b1;
        end
      end
    end
  end

  function automatic string tag_of(input vec_t v);
    if (v.er) return "R8";
    if (v.ab) return "R5 R6";
    case (v.dir)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic run_vec(input vec_t v, input int idx);
    int base, dbase;
    bit seen;
    string t;
    t = tag_of(v);
    base = log_n;
    dbase = done_cnt;
    seen = 0;
    @(negedge clk);
    resp_data = v.rdata;
    gnt       = v.gnt;
    req_dir   = v.dir;
    req_tc    = v.tc;
    req_word  = v.word;
    req_addr  = v.addr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (xfer_done) seen = 1;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (xfer_done) seen = 1;
    end
    chk(seen, t, $sformatf("vec %0d done strobe", idx), 32'(seen), 32'd1);
    chk(xfer_abort == v.ab, t, $sformatf("vec %0d abort flag", idx), 32'(xfer_abort), 32'(v.ab));
    chk(xfer_err == v.er, t, $sformatf("vec %0d error flag", idx), 32'(xfer_err), 32'(v.er));
    repeat (3) @(negedge clk);
    chk(log_n - base == int'(v.n), t, $sformatf("vec %0d cycle count", idx), 32'(log_n - base), 32'(v.n));
    chk(done_cnt - dbase == 1, t, $sformatf("vec %0d done pulses", idx), 32'(done_cnt - dbase), 32'd1);
    if (v.n >= 1 && log_n - base >= 1) begin
      chk(lg_kind[base % 64] == v.k0, t, $sformatf("vec %0d first cycle kind", idx), 32'(lg_kind[base % 64]), 32'(v.k0));
      chk(lg_addr[base % 64] == v.a0, "R3", $sformatf("vec %0d first cycle addr", idx), lg_addr[base % 64], v.a0);
      chk(lg_be[base % 64] == v.b0, "R7", $sformatf("vec %0d first cycle be", idx), 32'(lg_be[base % 64]), 32'(v.b0));
    end
    if (v.n == 2 && log_n - base >= 2) begin
      chk(lg_kind[(base + 1) % 64] == v.k1, t, $sformatf("vec %0d second cycle kind", idx), 32'(lg_kind[(base + 1) % 64]), 32'(v.k1));
      chk(lg_addr[(base + 1) % 64] == v.a1, "R3", $sformatf("vec %0d second cycle addr", idx), lg_addr[(base + 1) % 64], v.a1);
      chk(lg_be[(base + 1) % 64] == v.b1, "R7", $sformatf("vec %0d second cycle be", idx), 32'(lg_be[(base + 1) % 64]), 32'(v.b1));
      chk(lg_wd[(base + 1) % 64] == v.wd, t, $sformatf("vec %0d store data", idx), lg_wd[(base + 1) % 64], v.wd);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WDOG", "run did not complete", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    int base, dbase;
    bit seen;
    rst_n = 1'b0;
    req_valid = 1'b0; req_dir = 2'd0; req_tc = 1'b0; req_word = 1'b0;
    req_addr = '0; gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !cyc_req && !xfer_done, "R11", "quiet in reset",
        32'({busy, cyc_req, xfer_done}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !cyc_req && !xfer_done && !xfer_abort && !xfer_err, "R11", "idle after reset",
        32'({busy, cyc_req, xfer_done, xfer_abort, xfer_err}), 32'd0);

    for (int v = 0; v < NV; v++) run_vec(VECS[v], v);

    // R10 and R12: wait states on the bus, extra requests while busy
    resp_wait = 3;
    base = log_n;
    dbase = done_cnt;
    seen = 0;
    @(negedge clk);
    resp_data = 32'h0000_0055;
    gnt = 1'b1; req_dir = 2'd1; req_tc = 1'b0; req_word = 1'b0;
    req_addr = 32'hB000_0000; req_valid = 1'b1;
    @(negedge clk);
    req_dir = 2'd3;
    for (int i = 0; i < 3; i++) @(negedge clk);
    chk(busy, "R10", "busy during waited cycle", 32'(busy), 32'd1);
    req_valid = 1'b0;
    for (int i = 0; i < 60 && !seen; i++) begin
      @(negedge clk);
      if (xfer_done) seen = 1;
    end
    repeat (4) @(negedge clk);
    chk(log_n - base == 2, "R10", "cycles with busy requests", 32'(log_n - base), 32'd2);
    chk(done_cnt - dbase == 1, "R10", "done pulses with busy requests", 32'(done_cnt - dbase), 32'd1);
    chk(lg_kind[base % 64] == IR, "R12", "waited load kind", 32'(lg_kind[base % 64]), 32'(IR));
    chk(lg_wd[(base + 1) % 64] == 32'h0000_0055, "R12", "waited store data",
        lg_wd[(base + 1) % 64], 32'h0000_0055);
    resp_wait = 0;

    // reset in the middle of a transfer
    @(negedge clk);
    req_dir = 2'd0; req_addr = 32'h0; req_valid = 1'b1; resp_wait = 5;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !cyc_req, "R11", "reset mid transfer", 32'({busy, cyc_req}), 32'd0);
    rst_n = 1'b1;
    resp_wait = 0;
    repeat (4) @(negedge clk);
    chk(!busy && !xfer_done, "R11", "idle after second reset", 32'({busy, xfer_done}), 32'd0);

    finish_run();
  end
endmodule